// File: doc/BRIEF.md
# Card interface power sequencer

This block governs the power state of a memory-card interface and the idle levels of the card clock, command and eight data pins. Software issues a power-control write carrying a two-bit requested state plus three configuration bits: a direction-output enable, a direction polarity and a feedback-clock enable. The sequencer accepts only legal moves between its three states and rejects everything else, raising a sticky sequence-error flag.

In the power-cycle state every card line is driven low, so a card cannot draw supply through its signal pins. In the power-off state every line is driven high. In the power-on state the pins are handed to the command/data path and the card clock gate may run. A card that is on can only be taken back to power-off by a reset. A full power-down therefore runs reset, power-cycle, power-off and then power-on.

The block also drives three direction outputs for external level-shifting transceivers: one for command, one for data line 0 and one shared by data lines 1 to 3. Their polarity is selectable.

Top module: `card_pwr_seq`

## Requirements
- R1: After a synchronous active-low reset, the state reads power-off (code 00) and the sequence-error flag is 0. The configuration bits (direction enable, direction polarity, feedback clock) are 0, all three direction outputs are 0 and the clock-run output is 0.
- R2: The state field codes are 00 power-off, 10 power-cycle and 11 power-on; 01 is reserved. An accepted write is visible on the state output from the clock edge that samples it.
- R3: In power-cycle, card clock, command and all data outputs are 0, every output enable is 1, and clock-run is 0.
- R4: In power-off, card clock, command and all data outputs are 1, every output enable is 1, and clock-run is 0.
- R5: In power-on, card clock, command value and enable, and the data values and enables equal the path inputs bit for bit, and clock-run is 1.
- R6: The accepted moves are power-off to power-cycle, power-cycle to power-off, power-off to power-on, and a write of the current state. An accepted write also loads the three configuration bits.
- R7: A write requesting power-on while in power-cycle is ignored: state and configuration bits are unchanged, and the sequence-error flag is set.
- R8: Every other write is ignored and sets the sequence-error flag. This covers power-on to power-off, power-on to power-cycle, and any write of the reserved code 01. Power-on is left only by reset, and the error flag stays set until reset.
- R9: The feedback-clock enable output shows the feedback-clock bit of the last accepted write.
- R10: With direction enable 0, all direction outputs are 0. With it set, each output is 1 exactly when the host-drive level of its group equals the polarity bit. The group drive levels are: command = command output enable; data 0 = data enable bit 0; data 1 to 3 = OR of data enable bits 1 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Power-control write strobe, one cycle |
| cfg_state | input | 2 | Requested state code |
| cfg_dir_en | input | 1 | Direction outputs enable |
| cfg_dir_pol | input | 1 | Direction outputs polarity |
| cfg_fbclk_en | input | 1 | Feedback clock enable |
| path_clk | input | 1 | Card clock level from the clock divider |
| path_cmd_o | input | 1 | Command value from the command path |
| path_cmd_oe | input | 1 | Command enable from the command path |
| path_dat_o | input | 8 | Data values from the data path |
| path_dat_oe | input | 8 | Data enables from the data path |
| card_clk | output | 1 | Card clock pin value |
| card_cmd_o | output | 1 | Command pin value |
| card_cmd_oe | output | 1 | Command pin enable |
| card_dat_o | output | 8 | Data pin values |
| card_dat_oe | output | 8 | Data pin enables |
| dir_cmd | output | 1 | Transceiver direction, command |
| dir_dat0 | output | 1 | Transceiver direction, data 0 |
| dir_dat123 | output | 1 | Transceiver direction, data 1 to 3 |
| fbclk_en | output | 1 | Feedback clock enable |
| clk_run | output | 1 | Card clock gate may run |
| pwr_state | output | 2 | Current state code |
| seq_err | output | 1 | Sticky illegal-sequence flag |

## Verification
The assertions assume the write strobe and the requested code are known, 0 or 1, at every sampled edge once reset is released. They also assume the path inputs are stable at those edges. The bench meets this by driving every input only on the falling edge. It keeps all inputs at defined values from time zero and pulses the strobe for exactly one cycle per write, so each write is sampled by a single rising edge.

// File: rtl/cps_pkg.sv
// Shared types for the card power sequencer.
package cps_pkg;
    // Two-bit power state code; the values are decoded by software.
    typedef enum logic [1:0] {
        PS_OFF = 2'b00,
        PS_RSV = 2'b01,
        PS_CYC = 2'b10,
        PS_ON  = 2'b11
    } pwr_st_e;

    // Configuration bits loaded by an accepted write.
    typedef struct packed {
        logic dir_en;
        logic dir_pol;
        logic fbclk_en;
    } pwr_cfg_t;
endpackage

// File: rtl/cps_seq_fsm.sv
// Power state register and transition filter.
// Accepts only legal state moves; rejected writes change nothing but set a
// sticky error flag. Assumes cfg_wr is a one-cycle strobe.
module cps_seq_fsm
    import cps_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr,
    input  logic [1:0] req_st,
    input  pwr_cfg_t req_cfg,
    output pwr_st_e  st,
    output pwr_cfg_t cfg,
    output logic     err
);
    pwr_st_e req_e;
    logic    legal;

    assign req_e = pwr_st_e'(req_st);

    // Decide whether the requested state is reachable from the current one.
    always_comb begin
        unique case (st)
            PS_OFF:  legal = (req_e == PS_OFF) || (req_e == PS_CYC) || (req_e == PS_ON);
            PS_CYC:  legal = (req_e == PS_CYC) || (req_e == PS_OFF);
            PS_ON:   legal = (req_e == PS_ON);
            default: legal = 1'b0;
        endcase
    end

    // State, configuration and error registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= PS_OFF;
            cfg <= '0;
            err <= 1'b0;
        end else if (wr) begin
            if (legal) begin
                st  <= req_e;
                cfg <= req_cfg;
            end else begin
                err <= 1'b1;
            end
        end
    end

    // R7: power-cycle is never followed directly by power-on.
    a_r7_cyc_never_on: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PS_CYC) |=> (st != PS_ON));

    // R6: power-on is only ever entered from power-off.
    a_r6_on_from_off: assert property (@(posedge clk) disable iff (!rst_n)
        (st != PS_ON) ##1 (st == PS_ON) |-> ($past(st) == PS_OFF));

    // R8: once on, stay on until reset.
    a_r8_on_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PS_ON) |=> (st == PS_ON));

    // R8: the error flag is sticky.
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R2: the reserved code is never held.
    a_r2_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        st != PS_RSV);
endmodule

// File: rtl/cps_pin_mux.sv
// Card pin multiplexer: forces idle levels in power-cycle (low) and
// power-off (high), and passes the command/data path through in power-on.
// Assumes the state input comes from cps_seq_fsm.
module cps_pin_mux
    import cps_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pwr_st_e           st,
    input  logic              p_clk,
    input  logic              p_cmd_o,
    input  logic              p_cmd_oe,
    input  logic [DATA_W-1:0] p_dat_o,
    input  logic [DATA_W-1:0] p_dat_oe,
    output logic              c_clk,
    output logic              c_cmd_o,
    output logic              c_cmd_oe,
    output logic [DATA_W-1:0] c_dat_o,
    output logic [DATA_W-1:0] c_dat_oe
);
    logic live;
    logic idle_lvl;

    assign live     = (st == PS_ON);
    assign idle_lvl = (st == PS_OFF);

    // Clock and command line selection.
    always_comb begin
        c_clk    = live ? p_clk    : idle_lvl;
        c_cmd_o  = live ? p_cmd_o  : idle_lvl;
        c_cmd_oe = live ? p_cmd_oe : 1'b1;
    end

    // One selector per data lane.
    for (genvar i = 0; i < DATA_W; i++) begin : g_lane
        always_comb begin
            c_dat_o[i]  = live ? p_dat_o[i]  : idle_lvl;
            c_dat_oe[i] = live ? p_dat_oe[i] : 1'b1;
        end
    end

    // R3: power-cycle drives every line low.
    a_r3_cyc_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PS_CYC) |-> (!c_clk && !c_cmd_o && (c_dat_o == '0) && c_cmd_oe && (&c_dat_oe)));

    // R5: power-on hands the pins to the path.
    a_r5_on_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PS_ON) |-> (c_clk == p_clk && c_dat_o == p_dat_o && c_dat_oe == p_dat_oe));
endmodule

// File: rtl/cps_dir_ctrl.sv
// Transceiver direction outputs for three line groups: command, data 0,
// data 1..3. Each is 1 when the group's drive level equals the polarity bit,
// and all are 0 while disabled. Assumes at least four data lanes.
module cps_dir_ctrl #(
    parameter int NGRP = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dir_en,
    input  logic            dir_pol,
    input  logic            cmd_oe,
    input  logic [3:0]      dat_oe,
    output logic [NGRP-1:0] dir
);
    logic [NGRP-1:0] drv;

    // Collapse the pin enables into one drive level per group.
    always_comb begin
        drv    = '0;
        drv[0] = cmd_oe;
        drv[1] = dat_oe[0];
        drv[2] = |dat_oe[3:1];
    end

    // One polarity stage per group.
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        always_comb dir[g] = dir_en & ~(drv[g] ^ dir_pol);
    end

    // R10: disabled direction outputs stay low.
    a_r10_dir_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_en |-> (dir == '0));
endmodule

// File: rtl/card_pwr_seq.sv
// Top of the card power sequencer: state filter, pin multiplexer and
// transceiver direction control. Reset is synchronous active low; the
// reset state is power-off with direction outputs inactive.
module card_pwr_seq
    import cps_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_state,
    input  logic              cfg_dir_en,
    input  logic              cfg_dir_pol,
    input  logic              cfg_fbclk_en,
    input  logic              path_clk,
    input  logic              path_cmd_o,
    input  logic              path_cmd_oe,
    input  logic [DATA_W-1:0] path_dat_o,
    input  logic [DATA_W-1:0] path_dat_oe,
    output logic              card_clk,
    output logic              card_cmd_o,
    output logic              card_cmd_oe,
    output logic [DATA_W-1:0] card_dat_o,
    output logic [DATA_W-1:0] card_dat_oe,
    output logic              dir_cmd,
    output logic              dir_dat0,
    output logic              dir_dat123,
    output logic              fbclk_en,
    output logic              clk_run,
    output logic [1:0]        pwr_state,
    output logic              seq_err
);
    localparam int NGRP = 3;

    pwr_st_e         st;
    pwr_cfg_t        cfg;
    pwr_cfg_t        req_cfg;
    logic [NGRP-1:0] dir_v;

    assign req_cfg = '{dir_en: cfg_dir_en, dir_pol: cfg_dir_pol, fbclk_en: cfg_fbclk_en};

    cps_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cfg_wr),
        .req_st  (cfg_state),
        .req_cfg (req_cfg),
        .st      (st),
        .cfg     (cfg),
        .err     (seq_err)
    );

    cps_pin_mux #(.DATA_W(DATA_W)) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .st       (st),
        .p_clk    (path_clk),
        .p_cmd_o  (path_cmd_o),
        .p_cmd_oe (path_cmd_oe),
        .p_dat_o  (path_dat_o),
        .p_dat_oe (path_dat_oe),
        .c_clk    (card_clk),
        .c_cmd_o  (card_cmd_o),
        .c_cmd_oe (card_cmd_oe),
        .c_dat_o  (card_dat_o),
        .c_dat_oe (card_dat_oe)
    );

    cps_dir_ctrl #(.NGRP(NGRP)) u_dir (
        .clk     (clk),
        .rst_n   (rst_n),
        .dir_en  (cfg.dir_en),
        .dir_pol (cfg.dir_pol),
        .cmd_oe  (card_cmd_oe),
        .dat_oe  (card_dat_oe[3:0]),
        .dir     (dir_v)
    );

    // Status and control outputs.
    always_comb begin
        dir_cmd    = dir_v[0];
        dir_dat0   = dir_v[1];
        dir_dat123 = dir_v[2];
        fbclk_en   = cfg.fbclk_en;
        clk_run    = (st == PS_ON);
        pwr_state  = st;
    end

    // R4: power-off drives every line high.
    a_r4_off_high: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'b00) |-> (card_clk && card_cmd_o && (&card_dat_o) && (&card_dat_oe) && !clk_run));

    // R1: the cycle after reset release starts in power-off with no error.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (pwr_state == 2'b00 && !seq_err && !dir_cmd && !dir_dat0 && !dir_dat123));
endmodule

// File: tb/card_pwr_seq_bench.sv
module card_pwr_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    // Vector: req[8:7] den[6] pol[5] fb[4] exp_st[3:2] exp_err[1] exp_fb[0]
    localparam logic [8:0] VEC [NVEC] = '{
        {2'b10, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0},  // OFF->CYC accepted
        {2'b11, 1'b1, 1'b1, 1'b1, 2'b10, 1'b1, 1'b0},  // CYC->ON rejected
        {2'b00, 1'b1, 1'b1, 1'b1, 2'b00, 1'b1, 1'b1},  // CYC->OFF accepted
        {2'b01, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1},  // reserved rejected
        {2'b11, 1'b1, 1'b0, 1'b0, 2'b11, 1'b1, 1'b0},  // OFF->ON accepted
        {2'b00, 1'b0, 1'b0, 1'b1, 2'b11, 1'b1, 1'b0},  // ON->OFF rejected
        {2'b10, 1'b0, 1'b0, 1'b1, 2'b11, 1'b1, 1'b0},  // ON->CYC rejected
        {2'b11, 1'b1, 1'b1, 1'b1, 2'b11, 1'b1, 1'b1}   // same state accepted
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_state = 2'b00;
    logic       cfg_dir_en = 1'b0, cfg_dir_pol = 1'b0, cfg_fbclk_en = 1'b0;
    logic       path_clk = 1'b1, path_cmd_o = 1'b1, path_cmd_oe = 1'b0;
    logic [7:0] path_dat_o = 8'hA5, path_dat_oe = 8'h0F;
    logic       card_clk, card_cmd_o, card_cmd_oe;
    logic [7:0] card_dat_o, card_dat_oe;
    logic       dir_cmd, dir_dat0, dir_dat123, fbclk_en, clk_run, seq_err;
    logic [1:0] pwr_state;

    int checks = 0;
    int errors = 0;
    logic m_den = 1'b0, m_pol = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    card_pwr_seq u_card_pwr_seq (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_state(cfg_state),
        .cfg_dir_en(cfg_dir_en), .cfg_dir_pol(cfg_dir_pol), .cfg_fbclk_en(cfg_fbclk_en),
        .path_clk(path_clk), .path_cmd_o(path_cmd_o), .path_cmd_oe(path_cmd_oe),
        .path_dat_o(path_dat_o), .path_dat_oe(path_dat_oe),
        .card_clk(card_clk), .card_cmd_o(card_cmd_o), .card_cmd_oe(card_cmd_oe),
        .card_dat_o(card_dat_o), .card_dat_oe(card_dat_oe),
        .dir_cmd(dir_cmd), .dir_dat0(dir_dat0), .dir_dat123(dir_dat123),
        .fbclk_en(fbclk_en), .clk_run(clk_run), .pwr_state(pwr_state), .seq_err(seq_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One-cycle write, then sample at the following falling edge.
    task automatic do_wr(input logic [1:0] s, input logic den, input logic pol, input logic fb);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_state = s; cfg_dir_en = den; cfg_dir_pol = pol; cfg_fbclk_en = fb;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        m_den = 1'b0; m_pol = 1'b0;
    endtask

    // Pin and direction checks from the expected state (R3, R4, R5, R10).
    task automatic chk_pins(input logic [1:0] es);
        logic       e_clk, e_cmd, e_cmdoe, dc, d0, d123;
        logic [7:0] e_dat, e_oe;
        if (es == 2'b11) begin
            e_clk = path_clk; e_cmd = path_cmd_o; e_cmdoe = path_cmd_oe;
            e_dat = path_dat_o; e_oe = path_dat_oe;
        end else begin
            e_clk = (es == 2'b00); e_cmd = e_clk; e_cmdoe = 1'b1;
            e_dat = {8{e_clk}}; e_oe = 8'hFF;
        end
        dc   = m_den & (e_cmdoe == m_pol);
        d0   = m_den & (e_oe[0] == m_pol);
        d123 = m_den & ((|e_oe[3:1]) == m_pol);
        if (es == 2'b10)      chk("R3 pins low", {card_clk, card_cmd_o, card_dat_o, card_dat_oe, clk_run}, {e_clk, e_cmd, e_dat, e_oe, 1'b0});
        else if (es == 2'b00) chk("R4 pins high", {card_clk, card_cmd_o, card_dat_o, card_dat_oe, clk_run}, {e_clk, e_cmd, e_dat, e_oe, 1'b0});
        else                  chk("R5 pins pass", {card_clk, card_cmd_o, card_cmd_oe, card_dat_o, card_dat_oe, clk_run}, {e_clk, e_cmd, e_cmdoe, e_dat, e_oe, 1'b1});
        chk("R10 dir", {dir_cmd, dir_dat0, dir_dat123}, {dc, d0, d123});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk("R1 reset", {pwr_state, seq_err, fbclk_en, dir_cmd, dir_dat0, dir_dat123, clk_run}, 8'b0);
        chk_pins(2'b00);

        // Table walk: R2, R6, R7, R8, R9
        for (int i = 0; i < NVEC; i++) begin
            logic [8:0] v;
            v = VEC[i];
            do_wr(v[8:7], v[6], v[5], v[4]);
            if (v[8:7] == v[3:2]) begin m_den = v[6]; m_pol = v[5]; end
            chk($sformatf("R2/R6/R7/R8 state vec%0d", i), pwr_state, v[3:2]);
            chk($sformatf("R7/R8 err vec%0d", i), seq_err, v[1]);
            chk($sformatf("R9 fbclk vec%0d", i), fbclk_en, v[0]);
            chk_pins(v[3:2]);
        end

        // R5 with other path patterns
        path_clk = 1'b0; path_cmd_o = 1'b0; path_cmd_oe = 1'b1;
        path_dat_o = 8'h3C; path_dat_oe = 8'hF0;
        @(negedge clk);
        chk_pins(2'b11);

        // R8 reset leaves power-on and clears the flag; R1
        do_reset();
        @(negedge clk);
        chk("R8 reset clears", {pwr_state, seq_err}, 3'b000);
        chk("R1 cfg cleared", {fbclk_en, dir_cmd, dir_dat0, dir_dat123}, 4'b0);

        // R6 direct OFF->ON after reset, direction enabled, polarity 1
        do_wr(2'b11, 1'b1, 1'b1, 1'b0);
        m_den = 1'b1; m_pol = 1'b1;
        chk("R6 off to on", {pwr_state, seq_err}, 3'b110);
        chk_pins(2'b11);
        // R10 polarity 1, no data enables: data groups inactive
        path_dat_oe = 8'h00; path_cmd_oe = 1'b1;
        @(negedge clk);
        chk("R10 pol1 dir", {dir_cmd, dir_dat0, dir_dat123}, 3'b100);
        // R10 only data line 2 driven: data 1..3 group active
        path_dat_oe = 8'h04;
        @(negedge clk);
        chk("R10 d123 group", {dir_cmd, dir_dat0, dir_dat123}, 3'b101);
        // R10 disable
        do_wr(2'b11, 1'b0, 1'b1, 1'b1);
        chk("R10 disabled", {dir_cmd, dir_dat0, dir_dat123}, 3'b000);
        chk("R9 fbclk on", fbclk_en, 1'b1);

        // R7 again after reset: CYC then ON rejected keeps config
        do_reset();
        do_wr(2'b10, 1'b1, 1'b0, 1'b0);
        do_wr(2'b11, 1'b0, 1'b1, 1'b1);
        chk("R7 cyc to on", {pwr_state, seq_err, fbclk_en}, 4'b1010);
        m_den = 1'b1; m_pol = 1'b0;
        chk_pins(2'b10);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule